// File: doc/BRIEF.md
# Receive Frame Address Filter

This block sits on the receive path between the flag/preamble detector and the receive buffer. It watches a byte stream in which a start marker opens each frame. The first data byte after that marker is the frame's address. The filter compares that address with an 8-bit match value that software programs through a small write port. The all-ones address is a broadcast and is accepted whatever value is programmed.

For an accepted frame, the address byte, the control byte and every following data byte go to storage one cycle later, in the order they arrived. The final byte carries an end flag, and an accept strobe marks the address byte. For a rejected frame nothing goes out, and the filter ignores input until the next start marker. A new match value is captured when a frame starts, so a write made in the middle of a frame changes only later frames.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset no output byte is valid, and the match value is 0x00, so a frame addressed to 0x00 is accepted with no prior write.
- R2: When the address byte equals the match value captured at frame start, the frame is accepted and `flt_hit` is high in the cycle that the forwarded address byte is valid.
- R3: An address byte of 0xFF is always accepted, whatever the match value.
- R4: When the address byte matches neither the match value nor 0xFF, no byte of that frame is forwarded, including the address byte, until the next start marker.
- R5: A forwarded byte appears on `out_byte` with `out_vld` high exactly one cycle after it was presented. Bytes keep their input order. `out_last` is high only on the byte that had `in_end` set, and `flt_hit` is high only on the address byte.
- R6: A write on `cfg_wr` updates the match value, but a comparison uses the value held when the frame's start marker arrived. A write in the same cycle as `in_start`, or at any point after it, first applies to the following frame.
- R7: A start marker in any state, even in the middle of an accepted or a discarded frame, abandons that frame and treats the next valid byte as a new address.
- R8: A byte with `in_end` set ends the frame. Valid bytes that arrive after it and before the next start marker are not forwarded.
- R9: The cycle carrying `in_start` has no data byte: `in_vld` and `in_byte` are ignored in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the match value |
| cfg_val | input | 8 | New match value |
| in_start | input | 1 | Start-of-frame marker (no data this cycle) |
| in_vld | input | 1 | Input byte valid |
| in_byte | input | 8 | Input byte |
| in_end | input | 1 | Input byte is the last of the frame |
| out_vld | output | 1 | Forwarded byte valid |
| out_byte | output | 8 | Forwarded byte |
| out_last | output | 1 | Forwarded byte is the last of the frame |
| flt_hit | output | 1 | Accept strobe, high with the forwarded address byte |

## Verification
The checker assumes that `in_end` is only meaningful together with `in_vld`, and that `in_start` is a single-cycle pulse. Its properties follow from the state, so a start marker that comes with a valid byte is still legal and is checked to forward nothing. The stimulus raises `in_end` only on valid bytes and holds `in_start` for exactly one cycle. On every start cycle it also drives a valid 0xFF byte, which would be a broadcast address if it were not ignored. All drives happen on the falling edge, so inputs are stable through every rising edge that the properties sample.

// File: rtl/rx_addr_filter_pkg.sv
package rx_addr_filter_pkg;
   typedef enum logic [1:0] {
      FLT_IDLE = 2'd0,
      FLT_ADDR = 2'd1,
      FLT_PASS = 2'd2,
      FLT_DROP = 2'd3
   } flt_state_e;
endpackage

// File: rtl/addr_match_reg.sv
module addr_match_reg #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_val,
   input  logic              frame_start,
   output logic [ADDR_W-1:0] cmp_val
);
   logic [ADDR_W-1:0] prog_q;
   logic [ADDR_W-1:0] snap_q;

   // programmed value, written at any time
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     prog_q <= '0;
      else if (wr_en) prog_q <= wr_val;
   end

   // snapshot used for comparison, refreshed only at frame start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           snap_q <= '0;
      else if (frame_start) snap_q <= prog_q;
   end

   assign cmp_val = snap_q;
endmodule

// File: rtl/addr_compare.sv
module addr_compare #(
   parameter int ADDR_W   = 8,
   parameter bit BCAST_EN = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] ref_val,
   output logic              hit
);
   logic exact;
   assign exact = (addr == ref_val);

   generate
      if (BCAST_EN) begin : g_bcast
         assign hit = exact | (&addr);
      end else begin : g_exact
         assign hit = exact;
      end
   endgenerate
endmodule

// File: rtl/byte_stage.sv
module byte_stage #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic [DATA_W-1:0] d_byte,
   input  logic              d_last,
   input  logic              d_first,
   output logic              q_vld,
   output logic [DATA_W-1:0] q_byte,
   output logic              q_last,
   output logic              q_first
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_vld   <= 1'b0;
         q_last  <= 1'b0;
         q_first <= 1'b0;
      end else begin
         q_vld   <= ld;
         q_last  <= ld & d_last;
         q_first <= ld & d_first;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q_byte <= '0;
      else if (ld) q_byte <= d_byte;
   end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
   import rx_addr_filter_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter bit BCAST_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [ADDR_W-1:0] cfg_val,
   input  logic              in_start,
   input  logic              in_vld,
   input  logic [ADDR_W-1:0] in_byte,
   input  logic              in_end,
   output logic              out_vld,
   output logic [ADDR_W-1:0] out_byte,
   output logic              out_last,
   output logic              flt_hit
);
   initial begin
      assert (ADDR_W >= 2 && ADDR_W <= 32)
         else $error("rx_addr_filter: ADDR_W out of range");
   end

   flt_state_e        state_q, state_d;
   logic [ADDR_W-1:0] cmp_val;
   logic              addr_hit;
   logic              fwd;
   logic              fwd_first;
   logic              byte_in;

   assign byte_in = in_vld & ~in_start;

   addr_match_reg #(.ADDR_W(ADDR_W)) u_match (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (cfg_wr),
      .wr_val      (cfg_val),
      .frame_start (in_start),
      .cmp_val     (cmp_val)
   );

   addr_compare #(.ADDR_W(ADDR_W), .BCAST_EN(BCAST_EN)) u_cmp (
      .addr    (in_byte),
      .ref_val (cmp_val),
      .hit     (addr_hit)
   );

   always_comb begin
      state_d   = state_q;
      fwd       = 1'b0;
      fwd_first = 1'b0;
      if (in_start) begin
         state_d = FLT_ADDR;
      end else if (byte_in) begin
         unique case (state_q)
            FLT_IDLE: state_d = FLT_IDLE;
            FLT_ADDR: begin
               if (addr_hit) begin
                  fwd       = 1'b1;
                  fwd_first = 1'b1;
                  state_d   = in_end ? FLT_IDLE : FLT_PASS;
               end else begin
                  state_d   = in_end ? FLT_IDLE : FLT_DROP;
               end
            end
            FLT_PASS: begin
               fwd = 1'b1;
               if (in_end) state_d = FLT_IDLE;
            end
            FLT_DROP: begin
               if (in_end) state_d = FLT_IDLE;
            end
            default: state_d = FLT_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= FLT_IDLE;
      else        state_q <= state_d;
   end

   byte_stage #(.DATA_W(ADDR_W)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld      (fwd),
      .d_byte  (in_byte),
      .d_last  (in_end),
      .d_first (fwd_first),
      .q_vld   (out_vld),
      .q_byte  (out_byte),
      .q_last  (out_last),
      .q_first (flt_hit)
   );
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk
   import rx_addr_filter_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter bit BCAST_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_start,
   input logic              in_vld,
   input logic [ADDR_W-1:0] in_byte,
   input logic              out_vld,
   input logic              out_last,
   input logic              flt_hit,
   input flt_state_e        state,
   input logic [ADDR_W-1:0] snap
);
   // R5
   last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_vld);

   // R5
   hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flt_hit |-> out_vld);

   // R9
   start_cycle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_start |=> !out_vld);

   // R8
   idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == FLT_IDLE && !in_start) |=> !out_vld);

   // R4
   drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == FLT_DROP && !in_start) |=> !out_vld);

   // R3
   bcast_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (BCAST_EN && state == FLT_ADDR && in_vld && !in_start && (&in_byte)) |=> flt_hit);

   // R6
   snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_start |=> $stable(snap));
endmodule

bind rx_addr_filter rx_addr_filter_chk #(.ADDR_W(ADDR_W), .BCAST_EN(BCAST_EN)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_start (in_start),
   .in_vld   (in_vld),
   .in_byte  (in_byte),
   .out_vld  (out_vld),
   .out_last (out_last),
   .flt_hit  (flt_hit),
   .state    (state_q),
   .snap     (cmp_val)
);

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [7:0] cfg_val = 8'h00;
   logic       in_start = 1'b0;
   logic       in_vld = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic       in_end = 1'b0;
   logic       out_vld;
   logic [7:0] out_byte;
   logic       out_last;
   logic       flt_hit;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rx_addr_filter u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_val(cfg_val),
      .in_start(in_start), .in_vld(in_vld), .in_byte(in_byte), .in_end(in_end),
      .out_vld(out_vld), .out_byte(out_byte), .out_last(out_last), .flt_hit(flt_hit)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic set_match(input logic [7:0] v);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_val = v;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   // output word packed as {vld, hit, last, byte}; byte masked when not valid
   function automatic logic [10:0] obs();
      return {out_vld, flt_hit, out_last, out_vld ? out_byte : 8'h00};
   endfunction

   // start marker (with a decoy 0xFF byte), then address and nb further bytes
   task automatic frame(input logic [7:0] addr, input int nb, input logic [7:0] seed,
                        input bit acc, input bit close, input string req);
      @(negedge clk);
      in_start = 1'b1; in_vld = 1'b1; in_byte = 8'hFF; in_end = 1'b0;
      @(negedge clk);
      in_start = 1'b0;
      chk(obs() == 11'h0, "R9 start byte dropped", 32'(obs()), 32'h0);
      for (int i = 0; i <= nb; i++) begin
         logic [7:0]  b;
         logic [10:0] e;
         b = (i == 0) ? addr : 8'(seed + 8'(i * 37));
         in_vld = 1'b1; in_byte = b; in_end = close && (i == nb);
         @(negedge clk);
         e = acc ? {1'b1, (i == 0), close && (i == nb), b} : 11'h0;
         chk(obs() == e, req, 32'(obs()), 32'(e));
      end
      in_vld = 1'b0; in_end = 1'b0;
   endtask

   initial begin
      logic [7:0] mlist [4];
      mlist[0] = 8'h00; mlist[1] = 8'h5A; mlist[2] = 8'hFE; mlist[3] = 8'hFF;
      repeat (3) @(negedge clk);
      chk(obs() == 11'h0, "R1 reset outputs", 32'(obs()), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(obs() == 11'h0, "R1 idle after reset", 32'(obs()), 32'h0);
      // R1: default match value is 0x00
      frame(8'h00, 2, 8'h10, 1'b1, 1'b1, "R1 default match");
      frame(8'h01, 1, 8'h20, 1'b0, 1'b1, "R1 default reject");

      // R2 R3 R4 R5 sweep: every address against several match values
      foreach (mlist[k]) begin
         set_match(mlist[k]);
         for (int a = 0; a < 256; a++) begin
            bit    acc;
            string tag;
            acc = (8'(a) == mlist[k]) || (a == 255);
            if (!acc)                               tag = "R4 reject";
            else if (a == 255 && mlist[k] != 8'hFF) tag = "R3 broadcast";
            else                                    tag = "R2 match R5 order";
            frame(8'(a), a % 3, 8'(a * 5), acc, 1'b1, tag);
         end
      end

      // R8: bytes after end and before a start are ignored
      set_match(8'h33);
      frame(8'h33, 1, 8'h40, 1'b1, 1'b1, "R8 setup");
      for (int i = 0; i < 3; i++) begin
         in_vld = 1'b1; in_byte = 8'h33; in_end = (i == 2);
         @(negedge clk);
         chk(obs() == 11'h0, "R8 idle bytes ignored", 32'(obs()), 32'h0);
      end
      in_vld = 1'b0; in_end = 1'b0;

      // R6: write during a frame changes only the next frame
      @(negedge clk);
      in_start = 1'b1; cfg_wr = 1'b1; cfg_val = 8'h44;
      @(negedge clk);
      in_start = 1'b0; cfg_wr = 1'b0;
      in_vld = 1'b1; in_byte = 8'h33; in_end = 1'b1;
      @(negedge clk);
      chk(obs() == {3'b111, 8'h33}, "R6 old value used", 32'(obs()), 32'({3'b111, 8'h33}));
      in_vld = 1'b0; in_end = 1'b0;
      frame(8'h44, 1, 8'h50, 1'b1, 1'b1, "R6 new value next frame");
      frame(8'h33, 1, 8'h50, 1'b0, 1'b1, "R6 old value gone");

      // R7: start inside a discarded frame and inside an accepted frame
      frame(8'h12, 2, 8'h60, 1'b0, 1'b0, "R7 open drop");
      frame(8'h44, 2, 8'h70, 1'b1, 1'b0, "R7 restart from drop");
      frame(8'h13, 2, 8'h80, 1'b0, 1'b1, "R7 restart from pass");

      // R5: gap in the input gives a gap in the output
      frame(8'h44, 0, 8'h00, 1'b1, 1'b0, "R5 gap setup");
      @(negedge clk);
      chk(obs() == 11'h0, "R5 gap", 32'(obs()), 32'h0);
      in_vld = 1'b1; in_byte = 8'hC3; in_end = 1'b1;
      @(negedge clk);
      chk(obs() == {3'b101, 8'hC3}, "R5 after gap", 32'(obs()), 32'({3'b101, 8'hC3}));
      in_vld = 1'b0; in_end = 1'b0;

      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog act=running exp=done");
      end
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule